// File: doc/BRIEF.md
# Configuration Register Target on a Two-Wire Serial Bus

This block is a two-wire serial bus target (I2C) that answers at the fixed 7-bit address 0x1C. It holds a small bank of 8-bit configuration registers and drives their contents as parallel outputs to neighbouring control logic. A controller writes by sending the address with the write bit, a register pointer, and one or more data bytes. It reads by writing the pointer, issuing a repeated START, and then sending the address with the read bit. In both directions the pointer advances by one after every byte. The pointer steps through the gaps in the map like any other address.

SCL and SDA arrive through two-flop synchronizers. START and STOP are SDA edges seen while SCL is high. The block pulls SDA low through an enable-only output, the way an open-drain pad is driven. It also watches for the high-speed entry byte, which has the form 00001xxx. It leaves that byte unacknowledged and raises a flag that stays up until the next STOP.

The controller is one state machine. Its states are `ST_IDLE`, `ST_ADDR`, `ST_ADDR_ACK`, `ST_PTR`, `ST_PTR_ACK`, `ST_WDATA`, `ST_WDATA_ACK`, `ST_RDATA`, `ST_RDATA_ACK` and `ST_IGNORE`.

- STOP from any state moves to `ST_IDLE`.
- START or repeated START from any state moves to `ST_ADDR`.
- In `ST_ADDR`, when the eighth bit ends:
  - a matching address moves to `ST_ADDR_ACK`;
  - any other byte, the entry byte included, moves to `ST_IGNORE`.
- `ST_ADDR_ACK` moves on at the SCL fall: to `ST_RDATA` when the read bit is set, otherwise to `ST_PTR`.
- `ST_PTR` moves to `ST_PTR_ACK` after eight bits.
- `ST_PTR_ACK` moves to `ST_WDATA`.
- `ST_WDATA` and `ST_WDATA_ACK` alternate, one pair per data byte.
- `ST_RDATA` moves to `ST_RDATA_ACK` after eight bits.
- `ST_RDATA_ACK` moves to `ST_RDATA` when the controller acknowledges, and to `ST_IGNORE` when it does not.

Top module: `i2c_cfg_target`

## Requirements
- R1: After reset, the configuration outputs hold these values, and the high-speed flag is low:

  | Address | Reset value |
  |---|---|
  | 0x10 | 0xD0 |
  | 0x11 | 0x90 |
  | 0x12 | 0x00 |
  | 0x13 | 0x19 |
  | 0x14 | 0x01 |
  | 0x16 | 0x63 |

- R2: The block acknowledges the address byte only when its upper seven bits equal 0x1C. Bit 0 of that byte is the read/write bit, with 1 meaning read. For any other address, SDA is never pulled low, and no register changes until the next START or STOP.
- R3: In a write, the pointer byte and every data byte are acknowledged. Data byte k (k = 0, 1, …) goes to address pointer+k.
- R4: A write changes only the writable bits. The writable masks are:

  | Address | Writable mask |
  |---|---|
  | 0x10 | 0xFF |
  | 0x11 | 0xFF |
  | 0x12 | 0x13 (bits 4, 1, 0) |
  | 0x13 | 0x1C (bits 4:2) |
  | 0x14 | 0xE1 (bits 7, 6, 5, 0) |
  | 0x16 | 0xF7 (every bit but 3) |

  All other bits keep their value.
- R5: The identity addresses are read-only. They read 0x03 = 0x10, 0x04 = 0x00, 0x05 = 0x00 and 0x06 = 0x88. Writes to them are acknowledged and have no effect.
- R6: After a pointer write, a repeated START and the address with the read bit, the block returns bytes from consecutive addresses, most significant bit first. It continues while the controller acknowledges and stops driving after a NACK.
- R7: A write to an unmapped address is acknowledged and discarded. A read from an unmapped address returns 0x00. Auto-increment passes through unmapped addresses.
- R8: A byte of the form 00001xxx right after START is not acknowledged and sets the high-speed flag.
- R9: The high-speed flag stays set across repeated STARTs and clears on STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock level from the pad |
| sda_in | input | 1 | Bus data level from the pad |
| sda_pull | output | 1 | Pull SDA low when 1, release when 0 |
| hs_mode | output | 1 | High-speed mode flag |
| vsel_hi_cfg | output | 8 | Contents of address 0x10 |
| vsel_lo_cfg | output | 8 | Contents of address 0x11 |
| pgood_cfg | output | 8 | Contents of address 0x12 |
| slew_cfg | output | 8 | Contents of address 0x13 |
| mode_cfg | output | 8 | Contents of address 0x14 |
| limit_cfg | output | 8 | Contents of address 0x16 |

## Verification
Every bus result takes effect on the third rising clock edge after the pin change that causes it: two edges for the synchronizer and one for the state machine. This applies to:
- a register update after the SCL fall that ends the eighth data bit;
- an SDA pull or release after an SCL fall;
- the high-speed flag set after the entry byte;
- the high-speed flag cleared after the STOP edge.

The bench updates its model when it makes that pin change. It compares outputs on every falling clock edge, except in the six cycles after any bus change. Acknowledge bits and read data are sampled in the middle of the SCL-high phase, long after the design's three-edge latency.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam int NREG   = 6;
    localparam int NID    = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_IGNORE
    } bus_state_t;

    // slot 0 is the lowest entry
    localparam logic [NREG-1:0][BYTE_W-1:0] REG_ADDR  = {8'h16, 8'h14, 8'h13, 8'h12, 8'h11, 8'h10};
    localparam logic [NREG-1:0][BYTE_W-1:0] REG_INIT  = {8'h63, 8'h01, 8'h19, 8'h00, 8'h90, 8'hD0};
    localparam logic [NREG-1:0][BYTE_W-1:0] REG_WMASK = {8'hF7, 8'hE1, 8'h1C, 8'h13, 8'hFF, 8'hFF};

    localparam logic [BYTE_W-1:0]          ID_BASE = 8'h03;
    localparam logic [NID-1:0][BYTE_W-1:0] ID_VAL  = {8'h88, 8'h00, 8'h00, 8'h10};

    localparam logic [4:0] HS_CODE_TOP = 5'b00001;
endpackage

// File: rtl/i2c_cfg_sync.sv
module i2c_cfg_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [1:0] scl_ff, sda_ff;
    logic       scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= 2'b11;
            sda_ff <= 2'b11;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[0], scl_in};
            sda_ff <= {sda_ff[0], sda_in};
            scl_q  <= scl_ff[1];
            sda_q  <= sda_ff[1];
        end
    end

    assign sda_lvl   = sda_ff[1];
    assign scl_rise  = scl_ff[1] & ~scl_q;
    assign scl_fall  = ~scl_ff[1] & scl_q;
    assign start_det = scl_ff[1] & scl_q & sda_q & ~sda_ff[1];
    assign stop_det  = scl_ff[1] & scl_q & ~sda_q & sda_ff[1];
endmodule

// File: rtl/i2c_cfg_regs.sv
module i2c_cfg_regs
    import i2c_cfg_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [BYTE_W-1:0]            wr_addr,
    input  logic [BYTE_W-1:0]            wr_data,
    input  logic [BYTE_W-1:0]            rd_addr,
    output logic [BYTE_W-1:0]            rd_data,
    output logic [NREG-1:0][BYTE_W-1:0]  cfg_q
);
    genvar g;
    generate
        for (g = 0; g < NREG; g++) begin : g_slot
            logic [BYTE_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q <= REG_INIT[g];
                else if (wr_en && wr_addr == REG_ADDR[g])
                    q <= (q & ~REG_WMASK[g]) | (wr_data & REG_WMASK[g]);
            end
            assign cfg_q[g] = q;
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++)
            if (rd_addr == REG_ADDR[i]) rd_data = cfg_q[i];
        for (int j = 0; j < NID; j++)
            if (rd_addr == ID_BASE + 8'(j)) rd_data = ID_VAL[j];
    end
endmodule

// File: rtl/i2c_cfg_target.sv
module i2c_cfg_target
    import i2c_cfg_pkg::*;
#(
    parameter logic [6:0] TARGET_ADDR = 7'h1C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull,
    output logic              hs_mode,
    output logic [BYTE_W-1:0] vsel_hi_cfg,
    output logic [BYTE_W-1:0] vsel_lo_cfg,
    output logic [BYTE_W-1:0] pgood_cfg,
    output logic [BYTE_W-1:0] slew_cfg,
    output logic [BYTE_W-1:0] mode_cfg,
    output logic [BYTE_W-1:0] limit_cfg
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    logic sda_lvl, scl_rise, scl_fall, start_det, stop_det;

    bus_state_t        state, state_nx;
    logic [CNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0] shreg, txreg, ptr, rd_data;
    logic              rw, host_ack;
    logic              byte_done, addr_hit, hs_code, counting, wr_en;
    logic [NREG-1:0][BYTE_W-1:0] cfg_q;

    i2c_cfg_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    assign byte_done = (bitcnt == LAST_BIT) && scl_fall;
    assign addr_hit  = (shreg[7:1] == TARGET_ADDR);
    assign hs_code   = (shreg[7:3] == HS_CODE_TOP);
    assign counting  = (state == ST_ADDR) || (state == ST_PTR) ||
                       (state == ST_WDATA) || (state == ST_RDATA);
    assign wr_en     = (state == ST_WDATA) && byte_done && !start_det && !stop_det;

    i2c_cfg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (ptr),
        .wr_data (shreg),
        .rd_addr (ptr),
        .rd_data (rd_data),
        .cfg_q   (cfg_q)
    );

    assign vsel_hi_cfg = cfg_q[0];
    assign vsel_lo_cfg = cfg_q[1];
    assign pgood_cfg   = cfg_q[2];
    assign slew_cfg    = cfg_q[3];
    assign mode_cfg    = cfg_q[4];
    assign limit_cfg   = cfg_q[5];

    // next state
    always_comb begin
        state_nx = state;
        if (stop_det)
            state_nx = ST_IDLE;
        else if (start_det)
            state_nx = ST_ADDR;
        else begin
            unique case (state)
                ST_IDLE, ST_IGNORE: state_nx = state;
                ST_ADDR:      if (byte_done) state_nx = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:  if (scl_fall)  state_nx = rw ? ST_RDATA : ST_PTR;
                ST_PTR:       if (byte_done) state_nx = ST_PTR_ACK;
                ST_PTR_ACK:   if (scl_fall)  state_nx = ST_WDATA;
                ST_WDATA:     if (byte_done) state_nx = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall)  state_nx = ST_WDATA;
                ST_RDATA:     if (byte_done) state_nx = ST_RDATA_ACK;
                ST_RDATA_ACK: if (scl_fall)  state_nx = host_ack ? ST_RDATA : ST_IGNORE;
                default:      state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt   <= '0;
            shreg    <= '0;
            txreg    <= '0;
            ptr      <= '0;
            rw       <= 1'b0;
            host_ack <= 1'b0;
            sda_pull <= 1'b0;
            hs_mode  <= 1'b0;
        end else if (stop_det) begin
            hs_mode  <= 1'b0;
            sda_pull <= 1'b0;
            bitcnt   <= '0;
        end else if (start_det) begin
            sda_pull <= 1'b0;
            bitcnt   <= '0;
        end else begin
            if (scl_rise && counting && bitcnt != LAST_BIT) begin
                bitcnt <= bitcnt + 1'b1;
                shreg  <= {shreg[BYTE_W-2:0], sda_lvl};
            end
            unique case (state)
                ST_ADDR: if (byte_done) begin
                    bitcnt <= '0;
                    if (addr_hit) begin
                        rw       <= shreg[0];
                        sda_pull <= 1'b1;
                    end else if (hs_code) begin
                        hs_mode  <= 1'b1;
                    end
                end
                ST_ADDR_ACK: if (scl_fall) begin
                    if (rw) begin
                        txreg    <= rd_data;
                        sda_pull <= ~rd_data[BYTE_W-1];
                    end else begin
                        sda_pull <= 1'b0;
                    end
                end
                ST_PTR: if (byte_done) begin
                    ptr      <= shreg;
                    sda_pull <= 1'b1;
                    bitcnt   <= '0;
                end
                ST_WDATA: if (byte_done) begin
                    ptr      <= ptr + 1'b1;
                    sda_pull <= 1'b1;
                    bitcnt   <= '0;
                end
                ST_PTR_ACK, ST_WDATA_ACK: if (scl_fall) sda_pull <= 1'b0;
                ST_RDATA: if (scl_fall) begin
                    if (bitcnt == LAST_BIT) begin
                        sda_pull <= 1'b0;
                        bitcnt   <= '0;
                    end else begin
                        txreg    <= {txreg[BYTE_W-2:0], 1'b0};
                        sda_pull <= ~txreg[BYTE_W-2];
                    end
                end
                ST_RDATA_ACK: begin
                    if (scl_rise) begin
                        host_ack <= ~sda_lvl;
                        if (!sda_lvl) ptr <= ptr + 1'b1;
                    end
                    if (scl_fall && host_ack) begin
                        txreg    <= rd_data;
                        sda_pull <= ~rd_data[BYTE_W-1];
                    end
                end
                ST_IDLE, ST_IGNORE: ;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/i2c_cfg_target_chk.sv
module i2c_cfg_target_chk
    import i2c_cfg_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input bus_state_t state,
    input logic       stop_det,
    input logic       wr_en,
    input logic       sda_pull,
    input logic       hs_mode,
    input logic [7:0] vsel_hi_cfg,
    input logic [7:0] pgood_cfg,
    input logic [7:0] slew_cfg
);
    // R9
    hs_stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !hs_mode);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_IGNORE) |-> !sda_pull);

    // R8
    hs_entry_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_mode) |-> (state == ST_IGNORE && !sda_pull));

    // R3
    cfg_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vsel_hi_cfg) |-> $past(wr_en));

    // R4
    pgood_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(pgood_cfg & 8'hEC));

    // R4
    slew_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(slew_cfg & 8'hE3));
endmodule

bind i2c_cfg_target i2c_cfg_target_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state),
    .stop_det    (stop_det),
    .wr_en       (wr_en),
    .sda_pull    (sda_pull),
    .hs_mode     (hs_mode),
    .vsel_hi_cfg (vsel_hi_cfg),
    .pgood_cfg   (pgood_cfg),
    .slew_cfg    (slew_cfg)
);

// File: tb/sim_i2c_cfg_target.sv
module sim_i2c_cfg_target;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_drv = 1'b1;
    logic sda_drv = 1'b1;
    logic sda_pull, hs_mode;
    logic [7:0] o_vh, o_vl, o_pg, o_sl, o_md, o_lm;
    wire sda_line = sda_drv & ~sda_pull;

    always #5 clk = ~clk;

    i2c_cfg_target u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_in      (scl_drv),
        .sda_in      (sda_line),
        .sda_pull    (sda_pull),
        .hs_mode     (hs_mode),
        .vsel_hi_cfg (o_vh),
        .vsel_lo_cfg (o_vl),
        .pgood_cfg   (o_pg),
        .slew_cfg    (o_sl),
        .mode_cfg    (o_md),
        .limit_cfg   (o_lm)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int settle = 0;
    bit live = 0;
    bit done = 0;
    logic [7:0] exp_cfg [6];
    bit exp_hs = 0;

    function automatic int slot(input logic [7:0] a);
        case (a)
            8'h10: return 0;
            8'h11: return 1;
            8'h12: return 2;
            8'h13: return 3;
            8'h14: return 4;
            8'h16: return 5;
            default: return -1;
        endcase
    endfunction

    function automatic logic [7:0] wmask(input int s);
        case (s)
            2: return 8'b0001_0011;
            3: return 8'b0001_1100;
            4: return 8'b1110_0001;
            5: return 8'b1111_0111;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [7:0] model_rd(input logic [7:0] a);
        case (a)
            8'h03: return 8'h10;
            8'h06: return 8'h88;
            default: return (slot(a) >= 0) ? exp_cfg[slot(a)] : 8'h00;
        endcase
    endfunction

    task automatic model_wr(input logic [7:0] a, input logic [7:0] d);
        int s = slot(a);
        if (s >= 0) exp_cfg[s] = (exp_cfg[s] & ~wmask(s)) | (d & wmask(s));
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (settle > 0) settle = settle - 1;
        else if (live && !done) begin
            chk("R4 per-clock cfg state", {16'h0, o_vh, o_vl, o_pg, o_sl, o_md, o_lm},
                {16'h0, exp_cfg[0], exp_cfg[1], exp_cfg[2], exp_cfg[3], exp_cfg[4], exp_cfg[5]});
            chk("R8/R9 per-clock hs flag", {63'h0, hs_mode}, {63'h0, exp_hs});
        end
    end

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drv(input logic c, input logic d);
        scl_drv = c;
        sda_drv = d;
        settle = 6;
    endtask

    task automatic bus_start();
        drv(scl_drv, 1'b1); hold(Q);
        drv(1'b1, 1'b1);    hold(Q);
        drv(1'b1, 1'b0);    hold(Q);
        drv(1'b0, 1'b0);    hold(Q);
    endtask

    task automatic bus_stop();
        drv(1'b0, 1'b0); hold(Q);
        drv(1'b1, 1'b0); hold(Q);
        drv(1'b1, 1'b1); exp_hs = 0; hold(Q);
    endtask

    task automatic send_bits(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            drv(1'b0, b[i]); hold(Q);
            drv(1'b1, b[i]); hold(Q);
            drv(1'b0, b[i]); hold(2);
        end
    endtask

    task automatic get_ack(output bit a);
        drv(1'b0, 1'b1); hold(Q);
        drv(1'b1, 1'b1); hold(Q/2);
        a = (sda_line === 1'b0);
        hold(Q/2);
        drv(1'b0, 1'b1); hold(2);
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit nack);
        for (int i = 7; i >= 0; i--) begin
            drv(1'b0, 1'b1); hold(Q);
            drv(1'b1, 1'b1); hold(Q/2);
            b[i] = sda_line;
            hold(Q/2);
            drv(1'b0, 1'b1); hold(2);
        end
        drv(1'b0, nack); hold(Q);
        drv(1'b1, nack); hold(Q);
        drv(1'b0, nack); hold(2);
    endtask

    task automatic wr_txn(input logic [6:0] a7, input logic [7:0] ptr,
                          input logic [7:0] d[$], input bit do_stop);
        bit ak;
        bit hit = (a7 == 7'h1C);
        bus_start();
        send_bits({a7, 1'b0}); get_ack(ak);
        chk("R2 address ack", {63'h0, ak}, {63'h0, hit});
        send_bits(ptr); get_ack(ak);
        chk("R2/R3 pointer ack", {63'h0, ak}, {63'h0, hit});
        foreach (d[i]) begin
            send_bits(d[i]);
            if (hit) model_wr(ptr + 8'(i), d[i]);
            get_ack(ak);
            chk("R3/R7 data ack", {63'h0, ak}, {63'h0, hit});
        end
        if (do_stop) bus_stop();
    endtask

    task automatic rd_txn(input logic [7:0] ptr, input int n);
        bit ak;
        logic [7:0] b;
        bus_start();
        send_bits({7'h1C, 1'b0}); get_ack(ak);
        chk("R6 address ack", {63'h0, ak}, 64'h1);
        send_bits(ptr); get_ack(ak);
        chk("R6 pointer ack", {63'h0, ak}, 64'h1);
        bus_start();
        send_bits({7'h1C, 1'b1}); get_ack(ak);
        chk("R6 read address ack", {63'h0, ak}, 64'h1);
        for (int i = 0; i < n; i++) begin
            recv_byte(b, (i == n - 1));
            chk("R5/R6/R7 read data", {56'h0, b}, {56'h0, model_rd(ptr + 8'(i))});
        end
        bus_stop();
    endtask

    initial begin
        bit ak;
        exp_cfg[0] = 8'hD0; exp_cfg[1] = 8'h90; exp_cfg[2] = 8'h00;
        exp_cfg[3] = 8'h19; exp_cfg[4] = 8'h01; exp_cfg[5] = 8'h63;
        hold(5);
        rst_n = 1'b1;
        hold(2);
        // R1 reset state
        chk("R1 reset 0x10", {56'h0, o_vh}, 64'hD0);
        chk("R1 reset 0x11", {56'h0, o_vl}, 64'h90);
        chk("R1 reset 0x12", {56'h0, o_pg}, 64'h00);
        chk("R1 reset 0x13", {56'h0, o_sl}, 64'h19);
        chk("R1 reset 0x14", {56'h0, o_md}, 64'h01);
        chk("R1 reset 0x16", {56'h0, o_lm}, 64'h63);
        chk("R1 reset hs flag", {63'h0, hs_mode}, 64'h0);
        chk("R1 reset sda released", {63'h0, sda_pull}, 64'h0);
        live = 1;

        // R3 two-byte write into the fully writable pair
        wr_txn(7'h1C, 8'h10, '{8'h55, 8'h3C}, 1'b1);
        chk("R3 written 0x10", {56'h0, o_vh}, 64'h55);
        // R4 R7 masked writes, running through the hole at 0x15
        wr_txn(7'h1C, 8'h12, '{8'hFF, 8'hFF, 8'hFF, 8'h00, 8'hAA}, 1'b1);
        chk("R4 masked 0x12", {56'h0, o_pg}, 64'h13);
        chk("R4 masked 0x13", {56'h0, o_sl}, 64'h1D);
        chk("R4 masked 0x16", {56'h0, o_lm}, 64'hA2);
        // R5 identity writes ignored, then read back
        wr_txn(7'h1C, 8'h03, '{8'hFF, 8'hFF}, 1'b1);
        rd_txn(8'h03, 4);
        // R6 R7 multi-byte read across unmapped addresses
        rd_txn(8'h12, 6);
        // R6 single-byte read
        rd_txn(8'h10, 1);
        // R2 foreign address ignored
        wr_txn(7'h1D, 8'h10, '{8'h00, 8'h00}, 1'b1);
        chk("R2 foreign write ignored", {56'h0, o_vh}, 64'h55);
        // R8 R9 high-speed entry, traffic under Sr, then STOP
        bus_start();
        send_bits(8'h09);
        exp_hs = 1;
        get_ack(ak);
        chk("R8 master code not acked", {63'h0, ak}, 64'h0);
        chk("R8 hs flag set", {63'h0, hs_mode}, 64'h1);
        wr_txn(7'h1C, 8'h11, '{8'h42}, 1'b0);
        chk("R9 hs kept over Sr", {63'h0, hs_mode}, 64'h1);
        rd_txn(8'h11, 2);
        hold(Q);
        chk("R9 stop exits hs", {63'h0, hs_mode}, 64'h0);
        chk("R3 high-speed write 0x11", {56'h0, o_vl}, 64'h42);
        hold(Q);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog R1-run hung actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule